// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Byte-Wide Register Access

This block is a 16-bit timer/counter driven by an incoming tick enable. A prescaler divides the tick by 1, 8, 32 or 128. Each prescaled step advances the counter in one of three counting modes: free-running, modulo against a programmable terminal value, or up/down (triangle) counting. A fourth mode value stops the counter without clearing it. Software reaches the timer through a small 8-bit register interface.

The interface has six registers. The control register holds the mode, the divider select and the interrupt enable. The status register holds a sticky overflow flag. Two byte registers give the count, and two more hold the terminal value. Reading the low count byte captures the high byte in a holding register, so a following read of the high byte gives a coherent 16-bit value. Any write to the low count byte clears the whole counter. The interrupt output is the overflow flag gated by the enable.

Top module: `tick_timer16`

## Requirements
- R1: After synchronous reset every register reads 0x00 and `irq` is low. Register map on `reg_addr`: 0 control, 1 status, 2 count low, 3 count high, 4 terminal low, 5 terminal high; other addresses read 0x00.
- R2: Control bits [1:0] select the mode: 00 halt, 01 free-running, 10 modulo, 11 up/down. In halt the count keeps its present value whatever ticks arrive. Any nonzero mode lets the count advance.
- R3: Control bits [3:2] = 0,1,2,3 divide the tick by 1, 8, 32, 128. The prescaler phase restarts while halted and whenever the counter is cleared, so K ticks after a start give exactly floor(K/divisor) steps.
- R4: In free-running mode the count rises by one per step. The step after 0xFFFF gives 0x0000 and sets the overflow flag.
- R5: In modulo mode the count rises to the terminal value (registers 4/5), then the next step gives 0x0000 and sets the overflow flag. The period is terminal+1 steps.
- R6: In up/down mode the count rises to the terminal value and then falls to 0x0000. The flag is set on the step that reaches 0x0000, so the period is 2×terminal steps. With a terminal of zero the count stays at 0 and each step sets the flag.
- R7: A read of address 2 returns the low count byte and captures the current high byte. A read of address 3 returns that captured byte, even if the count has moved since.
- R8: Any write to address 2 clears the full count to 0x0000, whatever the data. Writes to address 3 have no effect.
- R9: The overflow flag is status bit 0. It stays set until a status write with bit 0 = 0, and a status write with bit 0 = 1 leaves it unchanged. A set in the same cycle as a clearing write wins.
- R10: `irq` is high exactly when the overflow flag is set and control bit 4 (interrupt enable) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_en | input | 1 | Incoming count tick, one clock wide per tick |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (needed for the high-byte capture) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the addressed register, combinational |
| irq | output | 1 | Overflow interrupt request, level |

## Verification
The bound checker watches several rules on every cycle. The count holds while halted, holds on cycles with no tick, becomes zero after a low-byte write, and never passes the terminal value in modulo mode. The free-running wrap always comes with a set flag, the flag stays set until a clearing write, and the interrupt never rises without its enable. The bench's sweeps are needed for the rest: the exact step counts for each divisor, the full modulo and triangle sequences, the high-byte capture across a count change, and set-over-clear priority. Each of these depends on a sequence of operations, not on one cycle.

// File: rtl/tmr_pkg.sv
// Shared types and register addresses for the prescaled 16-bit timer.
// Assumes an 8-bit register bus with a 3-bit address.
package tmr_pkg;
    localparam int DATA_W = 8;
    localparam int ADDR_W = 3;
    localparam int CNT_W  = 2 * DATA_W;

    typedef enum logic [1:0] {
        MODE_HALT = 2'b00,
        MODE_FREE = 2'b01,
        MODE_WRAP = 2'b10,
        MODE_TRI  = 2'b11
    } tmr_mode_e;

    localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
    localparam logic [ADDR_W-1:0] A_STAT  = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNTLO = 3'd2;
    localparam logic [ADDR_W-1:0] A_CNTHI = 3'd3;
    localparam logic [ADDR_W-1:0] A_TRMLO = 3'd4;
    localparam logic [ADDR_W-1:0] A_TRMHI = 3'd5;
endpackage

// File: rtl/tmr_prescaler.sv
// Divides the incoming tick by 1, 8, 32 or 128 and emits one step per period.
// Assumes clr restarts the phase so that the first step after it takes a full period.
module tmr_prescaler #(
    parameter int PH_W = 7
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_in,
    input  logic       clr,
    input  logic [1:0] div_sel,
    output logic       step_o
);
    logic [PH_W-1:0] phase_q;
    logic [PH_W-1:0] limit;

    // Last phase value of the selected period.
    always_comb begin
        case (div_sel)
            2'd0:    limit = PH_W'(0);
            2'd1:    limit = PH_W'(7);
            2'd2:    limit = PH_W'(31);
            default: limit = PH_W'(127);
        endcase
    end

    assign step_o = tick_in && !clr && (phase_q >= limit);

    // Phase counter, cleared on reset, halt or counter clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clr)      phase_q <= '0;
        else if (tick_in)       phase_q <= (phase_q >= limit) ? '0 : phase_q + 1'b1;
    end
endmodule

// File: rtl/tmr_counter.sv
// 16-bit counter with free-running, modulo and up/down modes.
// Assumes step is a single-cycle enable. clr wins over step. Halt keeps the count.
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int W = CNT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic         clr,
    input  tmr_mode_e    mode,
    input  logic [W-1:0] term,
    output logic [W-1:0] cnt_o,
    output logic         ovf_o
);
    logic [W-1:0] cnt_q, cnt_n;
    logic         down_q, down_n;
    logic         wrap_c;

    // Next count, next direction and overflow for the current mode.
    always_comb begin
        cnt_n  = cnt_q + 1'b1;
        down_n = down_q;
        wrap_c = 1'b0;
        case (mode)
            MODE_FREE: wrap_c = (cnt_q == {W{1'b1}});
            MODE_WRAP: begin
                if (cnt_q >= term) begin
                    cnt_n  = '0;
                    wrap_c = 1'b1;
                end
            end
            MODE_TRI: begin
                if (term == '0) begin
                    cnt_n  = '0;
                    down_n = 1'b0;
                    wrap_c = 1'b1;
                end else if (!down_q && cnt_q >= term) begin
                    cnt_n  = cnt_q - 1'b1;
                    down_n = 1'b1;
                    wrap_c = (cnt_q == W'(1));
                end else if (down_q && cnt_q == '0) begin
                    cnt_n  = W'(1);
                    down_n = 1'b0;
                end else if (down_q) begin
                    cnt_n  = cnt_q - 1'b1;
                    wrap_c = (cnt_q == W'(1));
                end
            end
            default: cnt_n = cnt_q;
        endcase
    end

    // Count and direction registers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt_q  <= '0;
            down_q <= 1'b0;
        end else if (mode == MODE_HALT) begin
            down_q <= 1'b0;
        end else if (step) begin
            cnt_q  <= cnt_n;
            down_q <= down_n;
        end
    end

    assign cnt_o = cnt_q;
    assign ovf_o = step && !clr && (mode != MODE_HALT) && wrap_c;
endmodule

// File: rtl/tmr_ovf_flag.sv
// Sticky overflow flag: set by an event, cleared by a software write; set wins.
// Assumes set and clear are single-cycle strobes.
module tmr_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Flag register with set-over-clear priority.
    always_ff @(posedge clk) begin
        if (!rst_n)     flag_o <= 1'b0;
        else if (set_i) flag_o <= 1'b1;
        else if (clr_i) flag_o <= 1'b0;
    end
endmodule

// File: rtl/tick_timer16.sv
// Prescaled 16-bit timer with an 8-bit register interface, high-byte read capture,
// sticky overflow flag and gated interrupt. Assumes one register access per cycle.
module tick_timer16
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    tmr_mode_e         ctrl_mode;
    logic [1:0]        ctrl_div;
    logic              ctrl_ien;
    logic [CNT_W-1:0]  term_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] hi_hold_q;
    logic              ovf_flag;
    logic              step, ovf_evt;
    logic              cnt_clr, ps_clr;

    assign cnt_clr = reg_wr && (reg_addr == A_CNTLO);
    assign ps_clr  = cnt_clr || (ctrl_mode == MODE_HALT);

    // Control and terminal value registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_mode <= MODE_HALT;
            ctrl_div  <= 2'd0;
            ctrl_ien  <= 1'b0;
            term_q    <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                A_CTRL: begin
                    ctrl_mode <= tmr_mode_e'(reg_wdata[1:0]);
                    ctrl_div  <= reg_wdata[3:2];
                    ctrl_ien  <= reg_wdata[4];
                end
                A_TRMLO: term_q[DATA_W-1:0]     <= reg_wdata;
                A_TRMHI: term_q[CNT_W-1:DATA_W] <= reg_wdata;
                default: ;
            endcase
        end
    end

    // High byte captured on a low-byte read.
    always_ff @(posedge clk) begin
        if (!rst_n)                              hi_hold_q <= '0;
        else if (reg_rd && reg_addr == A_CNTLO)  hi_hold_q <= cnt_q[CNT_W-1:DATA_W];
    end

    tmr_prescaler u_pre (
        .clk(clk), .rst_n(rst_n), .tick_in(tick_en), .clr(ps_clr),
        .div_sel(ctrl_div), .step_o(step)
    );

    tmr_counter u_cnt (
        .clk(clk), .rst_n(rst_n), .step(step), .clr(cnt_clr), .mode(ctrl_mode),
        .term(term_q), .cnt_o(cnt_q), .ovf_o(ovf_evt)
    );

    tmr_ovf_flag u_flag (
        .clk(clk), .rst_n(rst_n), .set_i(ovf_evt),
        .clr_i(reg_wr && reg_addr == A_STAT && !reg_wdata[0]),
        .flag_o(ovf_flag)
    );

    // Read data multiplexer.
    always_comb begin
        case (reg_addr)
            A_CTRL:  reg_rdata = {3'b000, ctrl_ien, ctrl_div, ctrl_mode};
            A_STAT:  reg_rdata = {7'b0, ovf_flag};
            A_CNTLO: reg_rdata = cnt_q[DATA_W-1:0];
            A_CNTHI: reg_rdata = hi_hold_q;
            A_TRMLO: reg_rdata = term_q[DATA_W-1:0];
            A_TRMHI: reg_rdata = term_q[CNT_W-1:DATA_W];
            default: reg_rdata = '0;
        endcase
    end

    assign irq = ovf_flag && ctrl_ien;
endmodule

// File: rtl/tick_timer16_chk.sv
// Cycle-level rules of the timer, bound to its top module.
module tick_timer16_chk
    import tmr_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              tick_en,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [DATA_W-1:0] reg_wdata,
    input logic              irq,
    input logic [CNT_W-1:0]  cnt,
    input logic [1:0]        mode,
    input logic              flag,
    input logic              ien,
    input logic [CNT_W-1:0]  term
);
    logic lo_wr, term_wr, stat_clr;
    assign lo_wr    = reg_wr && reg_addr == A_CNTLO;
    assign term_wr  = reg_wr && (reg_addr == A_TRMLO || reg_addr == A_TRMHI);
    assign stat_clr = reg_wr && reg_addr == A_STAT && !reg_wdata[0];

    assert_halt_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !lo_wr) |=> cnt == $past(cnt));

    assert_no_tick_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !lo_wr) |=> cnt == $past(cnt));

    assert_wrap_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b01 && cnt == 16'hFFFF && !lo_wr)
        |=> (cnt == 16'hFFFF || (cnt == 16'h0000 && flag)));

    assert_mod_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && cnt <= term && !term_wr) |=> cnt <= term);

    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lo_wr |=> cnt == 16'h0000);

    assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !stat_clr) |=> flag);

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ien && flag));
endmodule

bind tick_timer16 tick_timer16_chk chk_i (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .irq(irq), .cnt(cnt_q),
    .mode(ctrl_mode), .flag(ovf_flag), .ien(ctrl_ien), .term(term_q)
);

// File: tb/tick_timer16_tb_top.sv
module tick_timer16_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       irq;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    tick_timer16 dut_i (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic rd_cnt(output int v);
        logic [7:0] lo, hi;
        rd(3'd2, lo);
        rd(3'd3, hi);
        v = {hi, lo};
    endtask

    task automatic ticks(input int n);
        if (n > 0) begin
            @(negedge clk);
            tick_en = 1'b1;
            repeat (n) @(negedge clk);
            tick_en = 1'b0;
        end
    endtask

    task automatic setup(input int mode, input int div, input int ien);
        wr(3'd0, 8'(mode | (div << 2) | (ien << 4)));
    endtask

    task automatic get_flag(output int f);
        logic [7:0] s;
        rd(3'd1, s);
        f = s[0];
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int v, f;
        logic [7:0] b;
        int ks[9] = '{0, 1, 7, 8, 9, 31, 33, 128, 300};
        int dv[4] = '{1, 8, 32, 128};

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state of every register and irq
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), b);
            chk("R1 reset read", b, 0);
        end
        chk("R1 irq after reset", irq, 0);

        // R2: halt mode ignores ticks
        ticks(20);
        rd_cnt(v);
        chk("R2 halted count", v, 0);

        // R3: divisor sweep, floor(K/div) steps after a start
        for (int d = 0; d < 4; d++) begin
            foreach (ks[i]) begin
                setup(0, d, 0);
                wr(3'd2, 8'h00);
                setup(1, d, 0);
                ticks(ks[i]);
                rd_cnt(v);
                chk($sformatf("R3 div=%0d K=%0d", dv[d], ks[i]), v, ks[i] / dv[d]);
            end
        end

        // R2: halt keeps the present value, restart continues from it
        setup(1, 0, 0);
        wr(3'd2, 8'h00);
        ticks(40);
        setup(0, 0, 0);
        ticks(25);
        rd_cnt(v);
        chk("R2 halt keeps count", v, 40);
        setup(1, 0, 0);
        ticks(5);
        rd_cnt(v);
        chk("R2 resume count", v, 45);

        // R8: low-byte write clears regardless of data; high-byte write ignored
        wr(3'd3, 8'h7E);
        rd_cnt(v);
        chk("R8 high write ignored", v, 45);
        wr(3'd2, 8'hA5);
        rd_cnt(v);
        chk("R8 low write clears", v, 0);

        // R7: high byte captured by the low-byte read
        ticks(300);
        rd(3'd2, b);
        chk("R7 low byte", b, 8'h2C);
        ticks(300);
        rd(3'd3, b);
        chk("R7 captured high byte", b, 8'h01);
        rd_cnt(v);
        chk("R7 coherent read", v, 600);

        // R4: free-running wrap at 0xFFFF
        wr(3'd1, 8'h00);
        setup(1, 0, 1);
        wr(3'd2, 8'h00);
        ticks(65535);
        rd_cnt(v);
        chk("R4 count at top", v, 16'hFFFF);
        get_flag(f);
        chk("R4 flag before wrap", f, 0);
        chk("R10 irq low before wrap", irq, 0);
        ticks(1);
        rd_cnt(v);
        chk("R4 count after wrap", v, 0);
        get_flag(f);
        chk("R4 flag after wrap", f, 1);
        chk("R10 irq with enable", irq, 1);

        // R10: enable gates irq
        setup(0, 0, 0);
        #1 chk("R10 irq without enable", irq, 0);

        // R9: write 1 keeps flag, write 0 clears it
        wr(3'd1, 8'h01);
        get_flag(f);
        chk("R9 write one keeps flag", f, 1);
        wr(3'd1, 8'h00);
        get_flag(f);
        chk("R9 write zero clears flag", f, 0);

        // R5: modulo sweep with terminal 5
        wr(3'd4, 8'd5);
        wr(3'd5, 8'd0);
        for (int n = 0; n < 14; n++) begin
            setup(0, 0, 0);
            wr(3'd2, 8'h00);
            wr(3'd1, 8'h00);
            setup(2, 0, 0);
            ticks(n);
            rd_cnt(v);
            chk($sformatf("R5 modulo n=%0d", n), v, n % 6);
            get_flag(f);
            chk($sformatf("R5 modulo flag n=%0d", n), f, (n >= 6) ? 1 : 0);
        end

        // R6: up/down sweep with terminal 4
        wr(3'd4, 8'd4);
        for (int n = 0; n < 21; n++) begin
            int p;
            setup(0, 0, 0);
            wr(3'd2, 8'h00);
            wr(3'd1, 8'h00);
            setup(3, 0, 0);
            ticks(n);
            rd_cnt(v);
            p = n % 8;
            chk($sformatf("R6 triangle n=%0d", n), v, (p <= 4) ? p : 8 - p);
            get_flag(f);
            chk($sformatf("R6 triangle flag n=%0d", n), f, (n >= 8) ? 1 : 0);
        end

        // R6: terminal zero holds at 0 and flags each step
        wr(3'd4, 8'd0);
        setup(0, 0, 0);
        wr(3'd2, 8'h00);
        wr(3'd1, 8'h00);
        setup(3, 0, 0);
        ticks(3);
        rd_cnt(v);
        chk("R6 zero terminal count", v, 0);
        get_flag(f);
        chk("R6 zero terminal flag", f, 1);

        // R9: set in the same cycle as a clearing write wins (modulo, terminal 0)
        setup(2, 0, 0);
        @(negedge clk);
        tick_en = 1'b1;
        @(negedge clk);
        reg_addr = 3'd1; reg_wdata = 8'h00; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; tick_en = 1'b0;
        get_flag(f);
        chk("R9 set beats clear", f, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule